// File: doc/BRIEF.md
# Phase-Pattern Correlator for Second-Marker Alignment

This block measures how well a chosen second-marker timing lines up with a balanced pseudo-random pattern of carrier phase flips. A second-marker pulse starts a run. The block then counts carrier-cycle strobes through a start delay, which is a fixed number of cycles plus a signed offset. After that it steps through the reference chips. At the last strobe of each chip period it takes one phase sample. The sample is added to a signed accumulator when the chip's reference bit is one and subtracted when it is zero.

When the final chip has been added, the sum is placed on the result port and a one-cycle done pulse is raised. A search routine outside the block can repeat runs with different offsets and compare the results. The defaults are 512 chips of 120 carrier cycles each and a 15500-cycle base delay, which is 200 ms of a 77.5 kHz carrier.

Top module: `prn_phase_correlator`

## Requirements
- R1: After reset, `result` is 0 and `done` and `busy` are low.
- R2: A `marker` pulse while `busy` is low starts a run, and `busy` is high from the next cycle. A strobe in the same cycle as the accepted marker is not counted.
- R3: The start delay is D = START_DLY + `start_ofs`, with a negative sum taken as 0. Counting strobes from 1 after the marker, chip i (0-based) is sampled at strobe number D + (i+1)*CPC. Phase values at all other strobes, and between strobes, have no effect.
- R4: Each sampled phase (signed two's complement) is added when the chip's reference bit is 1 and subtracted when it is 0. The accumulator is PHASE_W + log2(CHIPS) + 1 bits wide, so no sum overflows.
- R5: Reference bits come in pairs. Chip 2k takes bit 0 of a 9-bit register s, and chip 2k+1 takes the inverse of that bit. s starts at SEED and after each pair becomes {s[7:0], s[8]^s[4]}. This makes the pattern exactly balanced.
- R6: In the cycle after the strobe that samples the last chip, `done` is high for exactly one cycle, `result` holds the sum, and `busy` is already low.
- R7: A `marker` pulse while `busy` is high is ignored: the run and its result are unchanged.
- R8: `result` changes only when `done` rises and holds its value between runs. Each run starts from a cleared sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_stb | input | 1 | One-cycle strobe per carrier cycle |
| phase | input | PHASE_W | Signed phase measurement |
| marker | input | 1 | Second-marker pulse |
| start_ofs | input | OFS_W | Signed offset added to the start delay |
| result | output | PHASE_W+log2(CHIPS)+1 | Signed correlation sum of the last run |
| done | output | 1 | One-cycle pulse when `result` is updated |
| busy | output | 1 | Run in progress |

## Verification
`busy` is due one cycle after an accepted marker. `done`, together with the new `result`, is due one cycle after strobe number D + CHIPS*CPC. The bench drives every input on the falling edge and samples on the next falling edge. Each check therefore sees exactly one rising edge's effect, and the bench checks `done` after every strobe to confirm the pulse comes at that strobe and at no other. In the cycle after the pulse, the bench checks that `done` has dropped and that `result` holds its value.

// File: rtl/prn_phase_correlator.sv
module prn_phase_correlator #(
  parameter int CHIPS     = 512,
  parameter int CPC       = 120,
  parameter int START_DLY = 15500,
  parameter int PHASE_W   = 12,
  parameter int OFS_W     = 16,
  parameter logic [8:0] SEED = 9'h1A5,
  localparam int ACC_W = PHASE_W + $clog2(CHIPS) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     carrier_stb,
  input  logic signed [PHASE_W-1:0] phase,
  input  logic                     marker,
  input  logic signed [OFS_W-1:0]  start_ofs,
  output logic signed [ACC_W-1:0]  result,
  output logic                     done,
  output logic                     busy
);
  localparam int MAXD = START_DLY + 2 ** (OFS_W - 1);
  localparam int DW   = $clog2(MAXD + 1);
  localparam int CW   = $clog2(CPC);
  localparam int IW   = $clog2(CHIPS);

  function automatic logic [CHIPS-1:0] build_seq();
    logic [8:0] s;
    logic [CHIPS-1:0] r;
    s = SEED;
    r = '0;
    for (int k = 0; k < CHIPS / 2; k++) begin
      r[2*k]   = s[0];
      r[2*k+1] = ~s[0];
      s = {s[7:0], s[8] ^ s[4]};
    end
    return r;
  endfunction

  localparam logic [CHIPS-1:0] SEQ = build_seq();

  logic signed [DW+1:0]   dsum;
  logic [DW-1:0]          dly, wcnt;
  logic [CW-1:0]          cyc;
  logic [IW-1:0]          chip;
  logic signed [ACC_W-1:0] acc, ph_x, acc_nx;
  logic                   in_wait, chip_end, last;

  assign dsum     = $signed((DW+2)'(START_DLY)) + (DW+2)'(start_ofs);
  assign dly      = dsum[DW+1] ? '0 : dsum[DW-1:0];
  assign ph_x     = ACC_W'(phase);
  assign acc_nx   = SEQ[chip] ? acc + ph_x : acc - ph_x;
  assign in_wait  = (wcnt != '0);
  assign chip_end = busy && carrier_stb && !in_wait && (cyc == CW'(CPC - 1));
  assign last     = chip_end && (chip == IW'(CHIPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      acc    <= '0;
      wcnt   <= '0;
      cyc    <= '0;
      chip   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (marker) begin
          busy <= 1'b1;
          wcnt <= dly;
          cyc  <= '0;
          chip <= '0;
          acc  <= '0;
        end
      end else if (carrier_stb) begin
        if (in_wait) begin
          wcnt <= wcnt - 1'b1;
        end else if (!chip_end) begin
          cyc <= cyc + 1'b1;
        end else begin
          cyc  <= '0;
          chip <= chip + 1'b1;
          acc  <= acc_nx;
          if (last) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= acc_nx;
          end
        end
      end
    end
  end
endmodule

module prn_corr_chk #(
  parameter int RES_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    marker,
  input logic signed [RES_W-1:0] result,
  input logic                    done,
  input logic                    busy
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r2_start_from_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(marker));
  a_r7_marker_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && marker) |=> (busy || done));
  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind prn_phase_correlator prn_corr_chk #(.RES_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .marker(marker),
  .result(result), .done(done), .busy(busy)
);

// File: tb/sim_prn_phase_correlator.sv
module sim_prn_phase_correlator;
  localparam int CHIPS = 8, CPC = 3, START = 5, PW = 6, OW = 6;
  localparam logic [8:0] SEED = 9'h1A5;
  localparam int AW = PW + $clog2(CHIPS) + 1;

  logic clk = 0, rst_n = 0, stb = 0, marker = 0;
  logic signed [PW-1:0] phase = '0;
  logic signed [OW-1:0] ofs = '0;
  logic signed [AW-1:0] result;
  logic done, busy;
  int checks = 0, fails = 0;
  logic [CHIPS-1:0] ref_bits;

  always #2 clk = ~clk;

  prn_phase_correlator #(.CHIPS(CHIPS), .CPC(CPC), .START_DLY(START),
    .PHASE_W(PW), .OFS_W(OW), .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .carrier_stb(stb), .phase(phase),
    .marker(marker), .start_ofs(ofs), .result(result), .done(done), .busy(busy));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int ph_val(int mode, int n, int o);
    case (mode)
      0: return ((n * 7 + o + 64) % 61) - 30;
      1: return -32;
      2: return 31;
      default: return (n % 2 == 0) ? -32 : 31;
    endcase
  endfunction

  // R3 R4 R5 R6 R7 R8: one full run with independently computed sum
  task automatic run(input int o, input int mode, input bit stb_with_marker,
                     input int intr_at);
    int d, fin;
    longint expv, prev;
    d = START + o;
    if (d < 0) d = 0;
    fin = d + CHIPS * CPC;
    expv = 0;
    prev = result;
    ofs = OW'(o);
    @(negedge clk);
    marker = 1; stb = stb_with_marker; phase = PW'(-5);
    @(negedge clk);
    marker = 0; stb = 0;
    chk("R2 busy after marker", busy, 1);
    for (int n = 1; n <= fin; n++) begin
      int p;
      p = ph_val(mode, n, o);
      if (n > d && (n - d) % CPC == 0) begin
        int i;
        i = (n - d) / CPC - 1;
        expv += ref_bits[i] ? p : -p;
      end
      stb = 1; phase = PW'(p);
      marker = (n == intr_at);
      @(negedge clk);
      stb = 0; marker = 0;
      phase = PW'(p + 9);
      if (n < fin) begin
        chk("R3 no done before last chip", done, 0);
        chk("R8 result held during run", result, prev);
        @(negedge clk);
      end else begin
        chk("R6 done at last chip", done, 1);
        chk("R6 busy low at done", busy, 0);
        chk("R4 correlation sum", result, expv);
        @(negedge clk);
        chk("R6 done one cycle", done, 0);
        chk("R8 result holds after done", result, expv);
      end
    end
  endtask

  initial begin
    logic [8:0] s;
    s = SEED;
    for (int k = 0; k < CHIPS / 2; k++) begin
      ref_bits[2*k] = s[0];
      ref_bits[2*k+1] = ~s[0];
      s = {s[7:0], s[8] ^ s[4]};
    end
    repeat (3) @(negedge clk);
    chk("R1 result", result, 0);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 0, 0, -1);
    run(3, 0, 1, -1);
    run(-2, 3, 0, -1);
    run(-20, 0, 0, -1);
    run(0, 1, 0, -1);
    run(1, 2, 0, -1);
    run(0, 3, 0, 10);
    run(31, 0, 0, 4);
    // R7 ignored marker: the run above ended on its own schedule; idle stays idle
    repeat (4) @(negedge clk);
    chk("R7 idle after runs", busy, 0);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end
endmodule